// File: doc/BRIEF.md
# In-Order Commit Buffer with Multi-Wide Retirement

This block keeps in-flight micro-operations in a circular window, in the order the program issued them. The renaming stage claims up to four consecutive entries per cycle. Each entry records an architectural destination and whether the operation is a branch. The entry's index is also its physical register number, so later operations name a producer by that index. They read its value through a source-read port, which reports whether the result has arrived.

Execution units return results on a single writeback port. A writeback carries the entry index, the result value, an exception flag and a mispredict flag. Each cycle the block examines the oldest entries and commits up to three of them to an architectural register-file write interface. Retirement stops at the first entry that has not completed. It also stops after a mispredicted branch, which commits and then flushes every younger entry. An excepting entry at the head is never committed. It raises an exception indication carrying its index and flushes the whole window.

Top module: `inorder_commit_buffer`

## Requirements
- R1: An accepted allocation of N entries (N = `allocCnt`, 1 to 4) uses slots 0..N-1 of the allocation bus. Slot j receives index (tail + j) mod DEPTH, and indices wrap from DEPTH-1 to 0.
- R2: An allocation is refused as a whole (`allocAccept` low, nothing written) when the free entries, counted before any retirement in the same cycle, are fewer than `allocCnt`. `allocCnt` of 0 is never accepted.
- R3: A writeback to an allocated entry stores its result. Afterwards `rdReady` is 1 for that index and `rdData` returns the written value. An index never written, or one of DEPTH or above, reads `rdReady` 0.
- R4: A writeback whose index is not allocated changes nothing: no later read reports it ready.
- R5: Up to 3 entries retire per cycle, strictly oldest first. `retValid` bit k marks the k-th oldest entry, and set bits always form a prefix starting at bit 0. Retirement stops at the first entry that has not completed or that carries an exception.
- R6: A retiring slot k drives `retDest` (bits k*AREG_W upward) with the entry's destination and `retData` (bits k*DATA_W upward) with its result.
- R7: A completed branch entry written back with the mispredict flag retires, and in the same cycle `flushOut` rises and all younger entries are discarded. Afterwards the window is empty and the next allocation starts at index 0. An allocation offered in the flush cycle is refused. The mispredict flag has no effect on an entry not allocated as a branch.
- R8: When the oldest entry has completed with the exception flag, it is not committed. `retValid` is 0, `excValid` and `flushOut` are 1, and `excIdx` equals that entry's index. The window is then emptied.
- R9: After reset the window is empty: nothing retires, no index reads ready, and the first allocation begins at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocCnt | input | 3 | Number of entries requested this cycle (0 to 4) |
| allocDest | input | ALLOC_W*AREG_W | Architectural destination per allocation slot |
| allocBranch | input | ALLOC_W | Branch flag per allocation slot |
| allocAccept | output | 1 | Request accepted this cycle |
| allocIdx | output | ALLOC_W*IDX_W | Entry index (physical register) assigned per slot |
| wbValid | input | 1 | Writeback strobe |
| wbIdx | input | IDX_W | Entry being completed |
| wbData | input | DATA_W | Result value |
| wbExc | input | 1 | Operation raised an exception |
| wbMisp | input | 1 | Branch turned out mispredicted |
| rdIdx | input | IDX_W | Source-read index |
| rdData | output | DATA_W | Result stored at `rdIdx` |
| rdReady | output | 1 | `rdIdx` is allocated and its result has arrived |
| retValid | output | RET_W | Per-slot commit strobe, bit 0 oldest |
| retDest | output | RET_W*AREG_W | Architectural destination per commit slot |
| retData | output | RET_W*DATA_W | Value written per commit slot |
| excValid | output | 1 | Oldest entry faulted |
| excIdx | output | IDX_W | Index of the faulting entry |
| flushOut | output | 1 | Window is being emptied this cycle |

## Verification
On every cycle, assertions check several structural rules. Commit strobes form an oldest-first prefix, and a commit only touches an allocated, completed entry. A fault cycle commits nothing. A flush leaves the window empty on the next cycle, a refused request never grows the occupancy, and an unallocated writeback leaves the completion bits alone. The bench scenarios cover what depends on values and sequences. These include the exact indices handed out across the wrap point, and the refusal when the window is full or one entry short. They also cover the three-wide commit after results arrive out of order, the data and destination on each commit slot, the mispredict flush with a competing allocation, and a fault held back until it reaches the head.

// File: rtl/icb_pkg.sv
package icb_pkg;
  localparam int ALLOC_W = 4;
  localparam int RET_W   = 3;
  localparam int ACNT_W  = $clog2(ALLOC_W + 1);

  typedef struct packed {
    logic               flush;
    logic [ALLOC_W-1:0] allocWe;
    logic [RET_W-1:0]   retClr;
  } icbStrobe_t;
endpackage

// File: rtl/icb_ctrl.sv
module icb_ctrl import icb_pkg::*; #(
  parameter int DEPTH = 40,
  parameter int IDX_W = 6,
  parameter int CNT_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ACNT_W-1:0]        allocCnt,
  input  logic [RET_W-1:0]         slotDone,
  input  logic [RET_W-1:0]         slotExc,
  input  logic [RET_W-1:0]         slotMisp,
  output icbStrobe_t               strb,
  output logic [ALLOC_W*IDX_W-1:0] allocIdx,
  output logic [RET_W*IDX_W-1:0]   retIdx,
  output logic                     allocAccept,
  output logic [RET_W-1:0]         retValid,
  output logic                     excValid,
  output logic [IDX_W-1:0]         excIdx,
  output logic                     flushOut
);

  logic [IDX_W-1:0]  headQ, tailQ;
  logic [CNT_W-1:0]  countQ, freeSlots;
  logic [ACNT_W-1:0] retN, accN;
  logic              chainOn, mispHit, excHit;

  function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] base,
                                               input logic [ACNT_W-1:0] step);
    logic [IDX_W:0] sum;
    sum = {1'b0, base} + (IDX_W+1)'(step);
    if (sum >= (IDX_W+1)'(DEPTH)) sum = sum - (IDX_W+1)'(DEPTH);
    return sum[IDX_W-1:0];
  endfunction

  for (genvar j = 0; j < ALLOC_W; j++) begin : g_allocIdx
    assign allocIdx[j*IDX_W +: IDX_W] = advance(tailQ, ACNT_W'(j));
  end
  for (genvar k = 0; k < RET_W; k++) begin : g_retIdx
    assign retIdx[k*IDX_W +: IDX_W] = advance(headQ, ACNT_W'(k));
  end

  // retirement chain: oldest first, halts on incomplete/faulting entry,
  // and halts after a mispredicted branch that itself commits
  always_comb begin
    freeSlots = CNT_W'(DEPTH) - countQ;
    chainOn   = 1'b1;
    mispHit   = 1'b0;
    retValid  = '0;
    for (int k = 0; k < RET_W; k++) begin
      if (chainOn && (CNT_W'(k) < countQ) && slotDone[k] && !slotExc[k]) begin
        retValid[k] = 1'b1;
        if (slotMisp[k]) begin
          mispHit = 1'b1;
          chainOn = 1'b0;
        end
      end else begin
        chainOn = 1'b0;
      end
    end
    excHit      = (countQ != '0) && slotDone[0] && slotExc[0];
    flushOut    = mispHit || excHit;
    allocAccept = !flushOut && (allocCnt != '0) &&
                  (allocCnt <= ACNT_W'(ALLOC_W)) &&
                  (CNT_W'(allocCnt) <= freeSlots);
    accN        = allocAccept ? allocCnt : '0;
    retN        = ACNT_W'($countones(retValid));
    strb.flush  = flushOut;
    strb.retClr = retValid;
    for (int j = 0; j < ALLOC_W; j++) begin
      strb.allocWe[j] = allocAccept && (ACNT_W'(j) < allocCnt);
    end
  end

  assign excValid = excHit;
  assign excIdx   = headQ;

  always_ff @(posedge clk) begin
    if (!rstN || flushOut) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      headQ  <= advance(headQ, retN);
      tailQ  <= advance(tailQ, accN);
      countQ <= countQ + CNT_W'(accN) - CNT_W'(retN);
    end
  end

  for (genvar k = 1; k < RET_W; k++) begin : g_ordChk
    AST_RET_IN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
      retValid[k] |-> retValid[k-1]) else $error("commit slot gap"); // R5
  end

  AST_EXC_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (retValid == '0 && flushOut)) else $error("fault committed"); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> (countQ == '0 && headQ == '0 && tailQ == '0)) else $error("flush left entries"); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH)) else $error("occupancy overflow"); // R2

  AST_REFUSE_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (!allocAccept && !flushOut) |=> (countQ <= $past(countQ))) else $error("refused request grew window"); // R2

endmodule

// File: rtl/icb_store.sv
module icb_store import icb_pkg::*; #(
  parameter int DEPTH  = 40,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  parameter int AREG_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  icbStrobe_t                strb,
  input  logic [ALLOC_W*IDX_W-1:0]  allocIdx,
  input  logic [ALLOC_W*AREG_W-1:0] allocDest,
  input  logic [ALLOC_W-1:0]        allocBranch,
  input  logic [RET_W*IDX_W-1:0]    retIdx,
  input  logic                      wbValid,
  input  logic [IDX_W-1:0]          wbIdx,
  input  logic [DATA_W-1:0]         wbData,
  input  logic                      wbExc,
  input  logic                      wbMisp,
  input  logic [IDX_W-1:0]          rdIdx,
  output logic [DATA_W-1:0]         rdData,
  output logic                      rdReady,
  output logic [RET_W-1:0]          slotDone,
  output logic [RET_W-1:0]          slotExc,
  output logic [RET_W-1:0]          slotMisp,
  output logic [RET_W*AREG_W-1:0]   retDest,
  output logic [RET_W*DATA_W-1:0]   retData
);

  logic [DEPTH-1:0]  vldQ, doneQ, excQ, mispQ, brQ;
  logic [AREG_W-1:0] destQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic              wbHit, rdInRange;

  assign wbHit     = wbValid && (wbIdx < IDX_W'(DEPTH)) && vldQ[wbIdx];
  assign rdInRange = rdIdx < IDX_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      vldQ  <= '0;
      doneQ <= '0;
      excQ  <= '0;
      mispQ <= '0;
      brQ   <= '0;
    end else begin
      for (int k = 0; k < RET_W; k++) begin
        if (strb.retClr[k]) begin
          vldQ[retIdx[k*IDX_W +: IDX_W]]  <= 1'b0;
          doneQ[retIdx[k*IDX_W +: IDX_W]] <= 1'b0;
        end
      end
      if (wbHit) begin
        doneQ[wbIdx] <= 1'b1;
        excQ[wbIdx]  <= wbExc;
        mispQ[wbIdx] <= wbMisp && brQ[wbIdx];
      end
      for (int j = 0; j < ALLOC_W; j++) begin
        if (strb.allocWe[j]) begin
          vldQ[allocIdx[j*IDX_W +: IDX_W]]  <= 1'b1;
          doneQ[allocIdx[j*IDX_W +: IDX_W]] <= 1'b0;
          excQ[allocIdx[j*IDX_W +: IDX_W]]  <= 1'b0;
          mispQ[allocIdx[j*IDX_W +: IDX_W]] <= 1'b0;
          brQ[allocIdx[j*IDX_W +: IDX_W]]   <= allocBranch[j];
        end
      end
    end
  end

  // payload: no reset needed, qualified by the status bits above
  always_ff @(posedge clk) begin
    if (wbHit && !strb.flush) dataQ[wbIdx] <= wbData;
    for (int j = 0; j < ALLOC_W; j++) begin
      if (strb.allocWe[j]) destQ[allocIdx[j*IDX_W +: IDX_W]] <= allocDest[j*AREG_W +: AREG_W];
    end
  end

  assign rdReady = rdInRange && vldQ[rdIdx] && doneQ[rdIdx];
  assign rdData  = rdInRange ? dataQ[rdIdx] : '0;

  for (genvar k = 0; k < RET_W; k++) begin : g_slot
    logic [IDX_W-1:0] sIdx;
    assign sIdx        = retIdx[k*IDX_W +: IDX_W];
    assign slotDone[k] = vldQ[sIdx] && doneQ[sIdx];
    assign slotExc[k]  = excQ[sIdx];
    assign slotMisp[k] = mispQ[sIdx];
    assign retDest[k*AREG_W +: AREG_W] = destQ[sIdx];
    assign retData[k*DATA_W +: DATA_W] = dataQ[sIdx];

    AST_RET_DONE: assert property (@(posedge clk) disable iff (!rstN)
      strb.retClr[k] |-> (vldQ[sIdx] && doneQ[sIdx] && !excQ[sIdx])) else $error("commit of unfinished entry"); // R5
  end

  AST_WB_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbHit && strb.allocWe == '0 && strb.retClr == '0 && !strb.flush)
    |=> $stable(doneQ)) else $error("stray writeback took effect"); // R4

endmodule

// File: rtl/inorder_commit_buffer.sv
module inorder_commit_buffer import icb_pkg::*; #(
  parameter  int DEPTH  = 40,
  parameter  int DATA_W = 32,
  parameter  int AREG_W = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ACNT_W-1:0]         allocCnt,
  input  logic [ALLOC_W*AREG_W-1:0] allocDest,
  input  logic [ALLOC_W-1:0]        allocBranch,
  output logic                      allocAccept,
  output logic [ALLOC_W*IDX_W-1:0]  allocIdx,
  input  logic                      wbValid,
  input  logic [IDX_W-1:0]          wbIdx,
  input  logic [DATA_W-1:0]         wbData,
  input  logic                      wbExc,
  input  logic                      wbMisp,
  input  logic [IDX_W-1:0]          rdIdx,
  output logic [DATA_W-1:0]         rdData,
  output logic                      rdReady,
  output logic [RET_W-1:0]          retValid,
  output logic [RET_W*AREG_W-1:0]   retDest,
  output logic [RET_W*DATA_W-1:0]   retData,
  output logic                      excValid,
  output logic [IDX_W-1:0]          excIdx,
  output logic                      flushOut
);

  icbStrobe_t               strb;
  logic [RET_W*IDX_W-1:0]   retIdx;
  logic [RET_W-1:0]         slotDone, slotExc, slotMisp;

  icb_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .allocCnt(allocCnt),
    .slotDone(slotDone), .slotExc(slotExc), .slotMisp(slotMisp),
    .strb(strb), .allocIdx(allocIdx), .retIdx(retIdx),
    .allocAccept(allocAccept), .retValid(retValid),
    .excValid(excValid), .excIdx(excIdx), .flushOut(flushOut)
  );

  icb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .AREG_W(AREG_W)) i_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocIdx(allocIdx), .allocDest(allocDest), .allocBranch(allocBranch),
    .retIdx(retIdx), .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData),
    .wbExc(wbExc), .wbMisp(wbMisp), .rdIdx(rdIdx),
    .rdData(rdData), .rdReady(rdReady),
    .slotDone(slotDone), .slotExc(slotExc), .slotMisp(slotMisp),
    .retDest(retDest), .retData(retData)
  );

endmodule

// File: tb/test_inorder_commit_buffer.sv
module test_inorder_commit_buffer;
  import icb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 40;
  localparam int DATA_W = 32;
  localparam int AREG_W = 3;
  localparam int IDX_W  = 6;

  typedef struct packed {
    logic [2:0] aCnt;  logic [3:0] br;  logic wbOn;  logic [5:0] wbIdx;
    logic wbExc; logic wbMisp; logic [5:0] rdIdx; logic eAcc; logic [5:0] eTail;
    logic [2:0] eRet; logic [5:0] eHead; logic eExc; logic eFlush; logic eRd;
  } vec_t;

  function automatic vec_t mk(int aCnt, int br, int wbOn, int wbIdx, int wbExc, int wbMisp,
                              int rdIdx, int eAcc, int eTail, int eRet, int eHead,
                              int eExc, int eFlush, int eRd);
    vec_t v;
    v.aCnt = 3'(aCnt); v.br = 4'(br); v.wbOn = 1'(wbOn); v.wbIdx = 6'(wbIdx);
    v.wbExc = 1'(wbExc); v.wbMisp = 1'(wbMisp); v.rdIdx = 6'(rdIdx); v.eAcc = 1'(eAcc);
    v.eTail = 6'(eTail); v.eRet = 3'(eRet); v.eHead = 6'(eHead); v.eExc = 1'(eExc);
    v.eFlush = 1'(eFlush); v.eRd = 1'(eRd);
    return v;
  endfunction

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    mk(4,0,0, 0,0,0,63, 1, 0,0, 0,0,0,0),  // fill 0..3
    mk(4,0,1, 1,0,0,63, 1, 4,0, 0,0,0,0),  // fill 4..7, finish 1
    mk(0,0,1, 0,0,0, 1, 0, 8,0, 0,0,0,1),  // 1 done but head waits
    mk(0,0,1, 2,0,0,63, 0, 8,3, 0,0,0,0),  // commit 0,1
    mk(0,0,1, 3,0,1,63, 0, 8,1, 2,0,0,0),  // mispredict flag on non-branch
    mk(0,0,1, 7,0,0,63, 0, 8,1, 3,0,0,0),  // 3 commits, no flush
    mk(0,0,1, 6,0,0,63, 0, 8,0, 4,0,0,0),
    mk(0,0,1, 5,0,0,63, 0, 8,0, 4,0,0,0),
    mk(0,0,1, 4,0,0, 6, 0, 8,0, 4,0,0,1),
    mk(0,0,0, 0,0,0,63, 0, 8,7, 4,0,0,0),  // three-wide commit
    mk(0,0,0, 0,0,0,63, 0, 8,1, 7,0,0,0),
    mk(4,4,0, 0,0,0,63, 1, 8,0, 8,0,0,0),  // idx 10 is a branch
    mk(4,0,0, 0,0,0,63, 1,12,0, 8,0,0,0),
    mk(4,0,0, 0,0,0,63, 1,16,0, 8,0,0,0),
    mk(4,0,0, 0,0,0,63, 1,20,0, 8,0,0,0),
    mk(4,0,0, 0,0,0,63, 1,24,0, 8,0,0,0),
    mk(4,0,0, 0,0,0,63, 1,28,0, 8,0,0,0),
    mk(4,0,0, 0,0,0,63, 1,32,0, 8,0,0,0),
    mk(4,0,0, 0,0,0,63, 1,36,0, 8,0,0,0),  // 36..39
    mk(4,0,0, 0,0,0,63, 1, 0,0, 8,0,0,0),  // wrapped 0..3
    mk(4,0,0, 0,0,0,63, 1, 4,0, 8,0,0,0),  // window now full
    mk(1,0,0, 0,0,0,63, 0, 8,0, 8,0,0,0),
    mk(1,0,1, 8,0,0,63, 0, 8,0, 8,0,0,0),
    mk(2,0,0, 0,0,0,63, 0, 8,1, 8,0,0,0),  // full before same-cycle commit
    mk(2,0,0, 0,0,0,63, 0, 8,0, 9,0,0,0),  // one short
    mk(1,0,0, 0,0,0,63, 1, 8,0, 9,0,0,0),
    mk(0,0,1, 9,0,0,63, 0, 9,0, 9,0,0,0),
    mk(0,0,1,10,0,1,63, 0, 9,1, 9,0,0,0),  // branch 10 mispredicted
    mk(1,0,1,11,0,0,63, 0, 9,1,10,0,1,0),  // commit branch + flush
    mk(0,0,1,11,0,0,63, 0, 0,0, 0,0,0,0),  // stray writeback
    mk(3,0,0, 0,0,0,11, 1, 0,0, 0,0,0,0),
    mk(0,0,1, 1,1,0,63, 0, 3,0, 0,0,0,0),  // fault on 1
    mk(0,0,1, 0,0,0,63, 0, 3,0, 0,0,0,0),
    mk(0,0,0, 0,0,0,63, 0, 3,1, 0,0,0,0),
    mk(0,0,0, 0,0,0,63, 0, 3,0, 1,1,1,0),  // fault at head
    mk(4,0,0, 0,0,0, 2, 1, 0,0, 0,0,0,0)
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ACNT_W-1:0] allocCnt = '0;
  logic [ALLOC_W*AREG_W-1:0] allocDest = '0;
  logic [ALLOC_W-1:0] allocBranch = '0;
  logic allocAccept;
  logic [ALLOC_W*IDX_W-1:0] allocIdx;
  logic wbValid = 1'b0;
  logic [IDX_W-1:0] wbIdx = '0;
  logic [DATA_W-1:0] wbData = '0;
  logic wbExc = 1'b0, wbMisp = 1'b0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic [DATA_W-1:0] rdData;
  logic rdReady;
  logic [RET_W-1:0] retValid;
  logic [RET_W*AREG_W-1:0] retDest;
  logic [RET_W*DATA_W-1:0] retData;
  logic excValid, flushOut;
  logic [IDX_W-1:0] excIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inorder_commit_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) i_inorder_commit_buffer (
    .clk(clk), .rstN(rstN), .allocCnt(allocCnt), .allocDest(allocDest),
    .allocBranch(allocBranch), .allocAccept(allocAccept), .allocIdx(allocIdx),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData), .wbExc(wbExc), .wbMisp(wbMisp),
    .rdIdx(rdIdx), .rdData(rdData), .rdReady(rdReady), .retValid(retValid),
    .retDest(retDest), .retData(retData), .excValid(excValid), .excIdx(excIdx),
    .flushOut(flushOut)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: empty after reset, first allocation at index 0
    allocCnt = 3'd4;
    rdIdx = 6'd0;
    #1;
    chk(retValid == '0, "R9", "retValid after reset", int'(retValid), 0);
    chk(!excValid && !flushOut, "R9", "exc/flush after reset", int'({excValid, flushOut}), 0);
    chk(!rdReady, "R9", "rdReady after reset", int'(rdReady), 0);
    chk(allocAccept && allocIdx[IDX_W-1:0] == '0, "R9", "first alloc index", int'(allocIdx[IDX_W-1:0]), 0);
    allocCnt = '0;

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      allocCnt = TBL[r].aCnt;
      for (int j = 0; j < ALLOC_W; j++) begin
        allocDest[j*AREG_W +: AREG_W] = 3'(((int'(TBL[r].eTail) + j) % DEPTH) % 8);
      end
      allocBranch = TBL[r].br;
      wbValid = TBL[r].wbOn;
      wbIdx   = TBL[r].wbIdx;
      wbData  = 32'h100 + 32'(TBL[r].wbIdx);
      wbExc   = TBL[r].wbExc;
      wbMisp  = TBL[r].wbMisp;
      rdIdx   = TBL[r].rdIdx;
      #1;
      chk(allocAccept == TBL[r].eAcc, "R2", $sformatf("row %0d accept", r), int'(allocAccept), int'(TBL[r].eAcc));
      if (TBL[r].eAcc) begin
        for (int j = 0; j < int'(TBL[r].aCnt); j++) begin
          chk(int'(allocIdx[j*IDX_W +: IDX_W]) == (int'(TBL[r].eTail) + j) % DEPTH, "R1",
              $sformatf("row %0d slot %0d index", r, j), int'(allocIdx[j*IDX_W +: IDX_W]),
              (int'(TBL[r].eTail) + j) % DEPTH);
        end
      end
      chk(retValid == TBL[r].eRet, "R5", $sformatf("row %0d retValid", r), int'(retValid), int'(TBL[r].eRet));
      for (int k = 0; k < RET_W; k++) begin
        if (TBL[r].eRet[k] && retValid[k]) begin
          int hd;
          hd = (int'(TBL[r].eHead) + k) % DEPTH;
          chk(retData[k*DATA_W +: DATA_W] == 32'h100 + 32'(hd), "R6", $sformatf("row %0d slot %0d data", r, k),
              int'(retData[k*DATA_W +: DATA_W]), 32'h100 + hd);
          chk(int'(retDest[k*AREG_W +: AREG_W]) == hd % 8, "R6", $sformatf("row %0d slot %0d dest", r, k),
              int'(retDest[k*AREG_W +: AREG_W]), hd % 8);
        end
      end
      chk(excValid == TBL[r].eExc, "R8", $sformatf("row %0d excValid", r), int'(excValid), int'(TBL[r].eExc));
      if (TBL[r].eExc) begin
        chk(excIdx == TBL[r].eHead, "R8", $sformatf("row %0d excIdx", r), int'(excIdx), int'(TBL[r].eHead));
      end
      chk(flushOut == TBL[r].eFlush, "R7", $sformatf("row %0d flushOut", r), int'(flushOut), int'(TBL[r].eFlush));
      chk(rdReady == TBL[r].eRd, "R3/R4", $sformatf("row %0d rdReady idx %0d", r, TBL[r].rdIdx),
          int'(rdReady), int'(TBL[r].eRd));
      if (TBL[r].eRd) begin
        chk(rdData == 32'h100 + 32'(TBL[r].rdIdx), "R3", $sformatf("row %0d rdData", r),
            int'(rdData), 32'h100 + int'(TBL[r].rdIdx));
      end
    end

    // R9: reset in mid-run discards completed entries
    @(negedge clk);
    allocCnt = '0; allocBranch = '0;
    wbValid = 1'b1; wbIdx = 6'd0; wbData = 32'h100; wbExc = 1'b0; wbMisp = 1'b0;
    @(negedge clk);
    wbValid = 1'b0;
    rdIdx = 6'd0;
    #1;
    chk(rdReady, "R3", "entry 0 ready before reset", int'(rdReady), 1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    allocCnt = 3'd2;
    #1;
    chk(!rdReady, "R9", "entry 0 after mid-run reset", int'(rdReady), 0);
    chk(retValid == '0, "R9", "retValid after mid-run reset", int'(retValid), 0);
    chk(allocAccept && allocIdx[IDX_W-1:0] == '0, "R9", "alloc index after mid-run reset",
        int'(allocIdx[IDX_W-1:0]), 0);
    allocCnt = '0;
    @(negedge clk);
    finish_run();
  end

endmodule